// File: doc/BRIEF.md
# Snapshot Time-of-Day Register Block

This peripheral keeps a free-running time of day as a whole-seconds count and a sub-second microsecond count. The microsecond part advances once for every cycle in which the `us_tick` input is high. When it reaches the last value of a second, it rolls over to zero and the seconds count advances on that same tick.

Software reads the time through a small 32-bit register bus. A running clock cannot be read safely as two separate words, because the microsecond word may roll over between the two reads. To avoid this, software first writes any value to the capture offset. That write copies both live counts into a pair of hold registers in a single cycle. The two hold registers can then be read in either order, at any later time, and always agree with each other. A fixed read-only word at offset 0 tells software which optional peripherals (display, console, network) the system contains.

Reads have one cycle of latency. The value for a read presented in one cycle appears on `rd_data` in the next cycle. In every other cycle `rd_data` is zero.

Top module: `tod_snapshot_regs`

## Requirements
- R1: After reset, the live seconds and microseconds counts and both hold registers are zero, and `rd_data` is zero.
- R2: A read of offset 0 returns the feature word. Bit 0 is set when a display is present, bit 1 when a console is present, and bit 2 when a network interface is present, all taken from the `FEATURES` parameter. Bits 31..3 read as zero.
- R3: The live microsecond count increases by exactly one in each cycle where `us_tick` is high. It holds its value in every cycle where `us_tick` is low.
- R4: A tick that arrives when the microsecond count equals `US_PER_SEC-1` sets the microsecond count to 0 and adds one to the seconds count, both in that same cycle. The microsecond count never reaches `US_PER_SEC`.
- R5: A write to offset 4, whatever the write data, copies both live counts into the hold registers. If a tick arrives in the same cycle, the values copied are those from before that tick.
- R6: A read of offset 8 returns the held seconds value, and a read of offset 12 returns the held microseconds value. Each appears on `rd_data` in the cycle after the one in which `rd_en` is high.
- R7: The hold registers change only on a write to offset 4. Reads of any offset, and any number of ticks, leave them unchanged.
- R8: Reads of offset 4 and of any offset other than 0, 4, 8 and 12 return zero. Writes to offsets 0, 8 and 12, and to any unmapped offset, change no state.
- R9: In the cycle after a cycle with `rd_en` low, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-microsecond advance strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data (its value is not used by any register) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |

## Verification
The bench builds the block with `US_PER_SEC` set to 10 and `FEATURES` set to 3'b101. The small second length means that several seconds rollovers happen within a few dozen ticks. This brings three cases within reach of short directed runs: the wrap itself, a capture taken in the same cycle as a wrapping tick, and a seconds value above one. The sparse feature pattern shows that each feature bit lands in its own position and that the absent middle bit reads as zero.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int WORD_W = 32;

    // Byte offsets of the register window
    localparam int OFF_FEAT  = 0;
    localparam int OFF_LATCH = 4;
    localparam int OFF_SEC   = 8;
    localparam int OFF_USEC  = 12;

    typedef struct packed {
        logic [WORD_W-1:0] sec;
        logic [WORD_W-1:0] usec;
    } tod_time_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FEAT,
        SEL_LATCH,
        SEL_SEC,
        SEL_USEC
    } reg_sel_e;

endpackage

// File: rtl/tod_live_counter.sv
module tod_live_counter
    import tod_pkg::*;
#(
    parameter int US_PER_SEC = 1000000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    output tod_time_t live
);

    localparam logic [WORD_W-1:0] USEC_LAST = WORD_W'(US_PER_SEC - 1);

    tod_time_t time_d, time_q;

    always_comb begin
        time_d = time_q;
        if (tick) begin
            if (time_q.usec == USEC_LAST) begin
                time_d.usec = '0;
                time_d.sec  = time_q.sec + 1'b1;
            end else begin
                time_d.usec = time_q.usec + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
        end else begin
            time_q <= time_d;
        end
    end

    assign live = time_q;

endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot
    import tod_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      capture,
    input  tod_time_t live,
    output tod_time_t snap
);

    tod_time_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (capture) begin
            snap_d = live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign snap = snap_q;

endmodule

// File: rtl/tod_addr_decode.sv
module tod_addr_decode
    import tod_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFF_FEAT)) begin
            sel = SEL_FEAT;
        end else if (addr == ADDR_W'(OFF_LATCH)) begin
            sel = SEL_LATCH;
        end else if (addr == ADDR_W'(OFF_SEC)) begin
            sel = SEL_SEC;
        end else if (addr == ADDR_W'(OFF_USEC)) begin
            sel = SEL_USEC;
        end
    end

endmodule

// File: rtl/tod_read_port.sv
module tod_read_port
    import tod_pkg::*;
#(
    parameter int         FEAT_W   = 3,
    parameter logic [2:0] FEATURES = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  tod_time_t         snap,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] feat_word;
    logic [WORD_W-1:0] rdata_d, rdata_q;

    // One feature flag per low bit; everything above is zero
    for (genvar g = 0; g < WORD_W; g++) begin : g_feat
        if (g < FEAT_W) begin : g_flag
            assign feat_word[g] = FEATURES[g];
        end else begin : g_zero
            assign feat_word[g] = 1'b0;
        end
    end

    always_comb begin
        rdata_d = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_FEAT: rdata_d = feat_word;
                SEL_SEC:  rdata_d = snap.sec;
                SEL_USEC: rdata_d = snap.usec;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rd_data = rdata_q;

endmodule

// File: rtl/tod_snapshot_regs.sv
module tod_snapshot_regs
    import tod_pkg::*;
#(
    parameter int         US_PER_SEC = 1000000,
    parameter int         ADDR_W     = 8,
    parameter logic [2:0] FEATURES   = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data
);

    localparam int FEAT_W = 3;

    reg_sel_e  sel;
    logic      capture;
    tod_time_t live;
    tod_time_t snap;
    logic      wr_data_unused;

    // The capture register reacts to the strobe alone
    assign wr_data_unused = ^wr_data;

    tod_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    assign capture = wr_en && (sel == SEL_LATCH);

    tod_live_counter #(
        .US_PER_SEC (US_PER_SEC)
    ) u_live (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick),
        .live  (live)
    );

    tod_snapshot u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .live    (live),
        .snap    (snap)
    );

    tod_read_port #(
        .FEAT_W   (FEAT_W),
        .FEATURES (FEATURES)
    ) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (sel),
        .snap    (snap),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/tod_checker.sv
module tod_checker
    import tod_pkg::*;
#(
    parameter int         US_PER_SEC = 1000000,
    parameter int         ADDR_W     = 8,
    parameter logic [2:0] FEATURES   = 3'b111
) (
    input logic              clk,
    input logic              rst_n,
    input logic              us_tick,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rd_data,
    input logic              capture,
    input tod_time_t         live,
    input tod_time_t         snap
);

    localparam logic [31:0] USEC_LAST = 32'(US_PER_SEC - 1);

    p_usec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live.usec <= USEC_LAST);

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (us_tick && live.usec == USEC_LAST) |=>
            (live.usec == '0 && live.sec == $past(live.sec) + 1));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (us_tick && live.usec != USEC_LAST) |=>
            (live.usec == $past(live.usec) + 1 && $stable(live.sec)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !us_tick |=> $stable(live));

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (snap == $past(live)));

    p_snap_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap));

    p_feat_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_FEAT)) |=> (rd_data == 32'(FEATURES)));

    p_read_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_SEC)) |=> (rd_data == $past(snap.sec)));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

endmodule

bind tod_snapshot_regs tod_checker #(
    .US_PER_SEC (US_PER_SEC),
    .ADDR_W     (ADDR_W),
    .FEATURES   (FEATURES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .us_tick (us_tick),
    .rd_en   (rd_en),
    .addr    (addr),
    .rd_data (rd_data),
    .capture (capture),
    .live    (live),
    .snap    (snap)
);

// File: tb/tod_snapshot_regs_tb.sv
`timescale 1ns/1ps
module tod_snapshot_regs_tb;

    localparam int         US_PER_SEC = 10;
    localparam int         ADDR_W     = 8;
    localparam logic [2:0] FEATURES   = 3'b101;

    localparam logic [1:0] OP_TICK  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] arg;   // tick count, or expected read value
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{OP_READ,  8'd8,    32'd0,  4'd1},  // R1 held seconds zero
        '{OP_READ,  8'd12,   32'd0,  4'd1},  // R1 held usec zero
        '{OP_READ,  8'd0,    32'd5,  4'd2},  // R2 feature word
        '{OP_TICK,  8'd0,    32'd7,  4'd3},
        '{OP_WRITE, 8'd4,    32'd0,  4'd5},
        '{OP_READ,  8'd12,   32'd7,  4'd6},  // R6 usec after 7 ticks
        '{OP_READ,  8'd8,    32'd0,  4'd6},
        '{OP_TICK,  8'd0,    32'd5,  4'd3},
        '{OP_READ,  8'd12,   32'd7,  4'd7},  // R7 no refresh by ticks
        '{OP_WRITE, 8'd4,    32'd0,  4'd5},
        '{OP_READ,  8'd8,    32'd1,  4'd4},  // R4 one wrap
        '{OP_READ,  8'd12,   32'd2,  4'd4},
        '{OP_WRITE, 8'd8,    32'd0,  4'd8},  // R8 read-only offset
        '{OP_WRITE, 8'h40,   32'd0,  4'd8},  // R8 unmapped
        '{OP_READ,  8'd12,   32'd2,  4'd8},
        '{OP_READ,  8'h40,   32'd0,  4'd8},
        '{OP_READ,  8'd4,    32'd0,  4'd8},
        '{OP_TICK,  8'd0,    32'd18, 4'd4},
        '{OP_WRITE, 8'd4,    32'd0,  4'd5},
        '{OP_READ,  8'd8,    32'd3,  4'd4},  // R4 several wraps
        '{OP_READ,  8'd12,   32'd0,  4'd4}
    };

    logic              clk;
    logic              rst_n;
    logic              us_tick;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [31:0]       wr_data;
    logic              rd_en;
    logic [31:0]       rd_data;

    int  n_tests;
    int  n_fail;
    bit  done;

    tod_snapshot_regs #(
        .US_PER_SEC (US_PER_SEC),
        .ADDR_W     (ADDR_W),
        .FEATURES   (FEATURES)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        if (n > 0) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                us_tick = 1'b1;
            end
            @(negedge clk);
            us_tick = 1'b0;
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        addr    = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        v     = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        n_tests = 0;
        n_fail  = 0;
        done    = 1'b0;
        rst_n   = 1'b0;
        us_tick = 1'b0;
        addr    = '0;
        wr_en   = 1'b0;
        wr_data = '0;
        rd_en   = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 32'd0);
        rst_n = 1'b1;

        // Vector table walk
        for (int k = 0; k < NVEC; k++) begin
            case (VECS[k].op)
                OP_TICK:  do_ticks(int'(VECS[k].arg));
                OP_WRITE: do_write(VECS[k].addr, 32'hA5A5_0000 + 32'(k));
                default: begin
                    do_read(VECS[k].addr, v);
                    check($sformatf("R%0d vector %0d", VECS[k].req, k), v, VECS[k].arg);
                end
            endcase
        end

        // R9: idle cycle after a read drives zero
        @(negedge clk);
        check("R9 idle rd_data", rd_data, 32'd0);

        // R5: capture in the same cycle as a wrapping tick (live is 3 s, 0 us)
        do_ticks(9);
        @(negedge clk);
        us_tick = 1'b1;
        wr_en   = 1'b1;
        addr    = 8'd4;
        @(negedge clk);
        us_tick = 1'b0;
        wr_en   = 1'b0;
        do_read(8'd12, v);
        check("R5 pre-tick usec", v, 32'd9);
        do_read(8'd8, v);
        check("R5 pre-tick sec", v, 32'd3);
        do_write(8'd4, 32'd0);
        do_read(8'd8, v);
        check("R4 wrap on capture tick sec", v, 32'd4);
        do_read(8'd12, v);
        check("R4 wrap on capture tick usec", v, 32'd0);

        // R1: reset mid-run clears live and held values
        do_ticks(3);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(8'd12, v);
        check("R1 held usec after reset", v, 32'd0);
        do_write(8'd4, 32'd0);
        do_read(8'd8, v);
        check("R1 live sec after reset", v, 32'd0);

        // R3: no ticks for a while, live must hold
        repeat (20) @(negedge clk);
        do_write(8'd4, 32'hFFFF_FFFF);
        do_read(8'd12, v);
        check("R3 hold without tick", v, 32'd0);
        do_ticks(1);
        do_write(8'd4, 32'd0);
        do_read(8'd12, v);
        check("R3 single tick", v, 32'd1);

        // R7: repeated reads leave the held value alone
        do_ticks(4);
        do_read(8'd12, v);
        do_read(8'd12, v);
        check("R7 reread usec", v, 32'd1);

        finish_run();
    end

endmodule